// File: doc/BRIEF.md
# PWM Event Qualifier with Held Override

This block turns time-base events into two pulse-width-modulated levels, `out_a` and `out_b`. A separate time base supplies the running count, its direction, and single-cycle strobes for the zero and period points, all qualified by a time-base clock enable `tick`. The block holds two compare values. When the count equals a compare value while counting up, that is a compare event. Each output has its own action word. The word picks, for each event, whether the output is left alone, driven low, driven high or inverted.

On top of the event logic sits a held override. Software writes a staged force word that can pin either output low or high. The staged word is copied into the live override at a selectable point: counter zero, period, either of them, or on the very next `tick`. While an override is live, the event-driven level keeps evolving underneath. When the override is released, the output shows that level at once.

Configuration is written through a small word-wide write port with a 3-bit address.

Top module: `pwm_event_qualifier`

## Requirements
- R1: While `rst_n` is low, and after it is released, both outputs are low. Compare values, action words, the staged force word and the reload selection all reset to zero.
- R2: A 2-bit action code means: 00 leave the level, 01 drive low, 10 drive high, 11 invert. It takes effect at the clock edge on which `tick` is high and its event is present, and the output shows it right after that edge.
- R3: The action word fields are: bits [1:0] zero event, [3:2] period event, [5:4] compare-A-up event, [9:8] compare-B-up event. Both outputs see every event.
- R4: A compare event occurs only when `cnt_up` is 1 and `cnt` equals the compare value. An equal count while counting down changes nothing.
- R5: When several events are present on one tick, the present event with the highest priority whose code is not 00 decides. The order is compare B, then compare A, then period, then zero.
- R6: With `tick` low, no event, strobe or count changes any output.
- R7: The live force word holds out_a's field in bits [1:0] and out_b's field in bits [3:2]. Code 01 holds the output low and 10 holds it high; 00 and 11 leave the event level through. A held output ignores events at its pin.
- R8: The reload selection decides when the staged force word is copied to the live one on a `tick`: 00 on a zero strobe, 01 on a period strobe, 10 on either strobe, 11 on every tick. In mode 11 the new force therefore reaches the pin after the next tick.
- R9: Events keep updating the hidden level while a force is live. After release, the output shows the updated level.
- R10: Write addresses are: 0 compare A, 1 compare B, 2 action word A, 3 action word B, 4 staged force word (bits [3:0]), 5 reload selection (bits [1:0]). Writes take effect at the edge where `cfg_wr` is high.
- R11: Action word A = 0x001A with compare A = C and a period P gives a high level for counts 0..C-1 and P, and low otherwise. Word 0x0025 gives the complement. Output B behaves the same way with word 0x010A against compare B, over the same shared period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base clock enable |
| cnt | input | 16 | Time-base count value |
| cnt_up | input | 1 | 1 while the time base counts up |
| zero_hit | input | 1 | Count-at-zero strobe |
| period_hit | input | 1 | Count-at-period strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
The bench builds the block with its default widths: a 16-bit count, 16-bit action words and a 3-bit address. Because the bench drives the count and strobes directly instead of running a real time base, it can put any event combination on any single tick with small compare values. This covers coincident events, counting down across an equal compare value, and strobes without `tick`. Walking all four reload selections against chosen strobe sequences makes both when the override is copied and what the hidden level is on release visible at the pins.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_AT_ZERO   = 2'b00,
    RLD_AT_PERIOD = 2'b01,
    RLD_AT_EITHER = 2'b10,
    RLD_EVERY     = 2'b11
  } rld_e;

  localparam int NUM_OUT   = 2;
  localparam int FRC_FLD_W = 2;
  localparam int FRC_W     = NUM_OUT * FRC_FLD_W;

  // action word field offsets (decoded by the channel state logic)
  localparam int FLD_ZERO  = 0;
  localparam int FLD_PRD   = 2;
  localparam int FLD_CMPA  = 4;
  localparam int FLD_CMPB  = 8;

  // configuration addresses
  localparam logic [2:0] ADR_CMPA  = 3'd0;
  localparam logic [2:0] ADR_CMPB  = 3'd1;
  localparam logic [2:0] ADR_ACTA  = 3'd2;
  localparam logic [2:0] ADR_ACTB  = 3'd3;
  localparam logic [2:0] ADR_FRC   = 3'd4;
  localparam logic [2:0] ADR_RLD   = 3'd5;

  typedef struct packed {
    logic cmp_b;
    logic cmp_a;
    logic period;
    logic zero;
  } evt_t;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (code)
      ACT_LOW:    apply_act = 1'b0;
      ACT_HIGH:   apply_act = 1'b1;
      ACT_INVERT: apply_act = ~cur;
      default:    apply_act = cur;
    endcase
  endfunction

endpackage

// File: rtl/pwmaq_cfg_regs.sv
module pwmaq_cfg_regs
  import pwmaq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ACT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [CNT_W-1:0]              cmp_a,
  output logic [CNT_W-1:0]              cmp_b,
  output logic [NUM_OUT-1:0][ACT_W-1:0] act,
  output logic [FRC_W-1:0]              frc_stage,
  output logic [1:0]                    rld_sel
);

  localparam int CW = (CNT_W < DATA_W) ? CNT_W : DATA_W;
  localparam int AW = (ACT_W < DATA_W) ? ACT_W : DATA_W;

  logic [CNT_W-1:0]              cmp_a_d, cmp_b_d;
  logic [NUM_OUT-1:0][ACT_W-1:0] act_d;
  logic [FRC_W-1:0]              frc_d;
  logic [1:0]                    rld_d;

  always_comb begin
    cmp_a_d = cmp_a;
    cmp_b_d = cmp_b;
    act_d   = act;
    frc_d   = frc_stage;
    rld_d   = rld_sel;
    if (wr) begin
      case (3'(addr))
        ADR_CMPA: begin
          cmp_a_d        = '0;
          cmp_a_d[CW-1:0] = wdata[CW-1:0];
        end
        ADR_CMPB: begin
          cmp_b_d        = '0;
          cmp_b_d[CW-1:0] = wdata[CW-1:0];
        end
        ADR_ACTA: begin
          act_d[0]         = '0;
          act_d[0][AW-1:0] = wdata[AW-1:0];
        end
        ADR_ACTB: begin
          act_d[1]         = '0;
          act_d[1][AW-1:0] = wdata[AW-1:0];
        end
        ADR_FRC:  frc_d = wdata[FRC_W-1:0];
        ADR_RLD:  rld_d = wdata[1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a     <= '0;
      cmp_b     <= '0;
      act       <= '0;
      frc_stage <= '0;
      rld_sel   <= '0;
    end else if (wr) begin
      cmp_a     <= cmp_a_d;
      cmp_b     <= cmp_b_d;
      act       <= act_d;
      frc_stage <= frc_d;
      rld_sel   <= rld_d;
    end
  end

endmodule

// File: rtl/pwmaq_evt_detect.sv
module pwmaq_evt_detect
  import pwmaq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_up,
  input  logic             zero_hit,
  input  logic             period_hit,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output evt_t             evt
);

  always_comb begin
    evt.zero   = tick & zero_hit;
    evt.period = tick & period_hit;
    evt.cmp_a  = tick & cnt_up & (cnt == cmp_a);
    evt.cmp_b  = tick & cnt_up & (cnt == cmp_b);
  end

endmodule

// File: rtl/pwmaq_chan_state.sv
module pwmaq_chan_state
  import pwmaq_pkg::*;
#(
  parameter int ACT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  evt_t             evt,
  input  logic [ACT_W-1:0] act,
  output logic             lvl
);

  localparam int NUM_EVT = 4;

  logic [NUM_EVT-1:0]      hit;
  logic [NUM_EVT-1:0][1:0] code;
  logic                    lvl_d;

  // index order is priority order: higher index wins
  assign hit  = {evt.cmp_b, evt.cmp_a, evt.period, evt.zero};
  assign code = {act[FLD_CMPB +: 2], act[FLD_CMPA +: 2],
                 act[FLD_PRD  +: 2], act[FLD_ZERO +: 2]};

  always_comb begin
    logic [1:0] win;
    win = ACT_KEEP;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (hit[i] && (code[i] != ACT_KEEP)) win = code[i];
    end
    lvl_d = apply_act(win, lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl <= 1'b0;
    else if (tick) lvl <= lvl_d;
  end

endmodule

// File: rtl/pwmaq_force_ctl.sv
module pwmaq_force_ctl
  import pwmaq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             zero_hit,
  input  logic             period_hit,
  input  logic [1:0]       rld_sel,
  input  logic [FRC_W-1:0] frc_stage,
  output logic [FRC_W-1:0] frc_live
);

  logic load;

  always_comb begin
    case (rld_e'(rld_sel))
      RLD_AT_ZERO:   load = zero_hit;
      RLD_AT_PERIOD: load = period_hit;
      RLD_AT_EITHER: load = zero_hit | period_hit;
      default:       load = 1'b1;
    endcase
    load = load & tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frc_live <= '0;
    else if (load) frc_live <= frc_stage;
  end

endmodule

// File: rtl/pwm_event_qualifier.sv
module pwm_event_qualifier
  import pwmaq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ACT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_up,
  input  logic              zero_hit,
  input  logic              period_hit,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              out_a,
  output logic              out_b
);

  logic [CNT_W-1:0]              cmp_a_q, cmp_b_q;
  logic [NUM_OUT-1:0][ACT_W-1:0] act_q;
  logic [FRC_W-1:0]              shadow_q, force_q;
  logic [1:0]                    rld_q;
  evt_t                          evt;
  logic [NUM_OUT-1:0]            chan_lvl;
  logic [NUM_OUT-1:0]            pin_lvl;

  pwmaq_cfg_regs #(
    .CNT_W(CNT_W), .ACT_W(ACT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .act(act_q),
    .frc_stage(shadow_q), .rld_sel(rld_q)
  );

  pwmaq_evt_detect #(.CNT_W(CNT_W)) u_evt (
    .tick(tick), .cnt(cnt), .cnt_up(cnt_up), .zero_hit(zero_hit),
    .period_hit(period_hit), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .evt(evt)
  );

  pwmaq_force_ctl u_frc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .zero_hit(zero_hit),
    .period_hit(period_hit), .rld_sel(rld_q), .frc_stage(shadow_q),
    .frc_live(force_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    pwmaq_chan_state #(.ACT_W(ACT_W)) u_state (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt),
      .act(act_q[g]), .lvl(chan_lvl[g])
    );

    always_comb begin
      case (act_e'(force_q[g*FRC_FLD_W +: FRC_FLD_W]))
        ACT_LOW:  pin_lvl[g] = 1'b0;
        ACT_HIGH: pin_lvl[g] = 1'b1;
        default:  pin_lvl[g] = chan_lvl[g];
      endcase
    end
  end

  assign out_a = pin_lvl[0];
  assign out_b = pin_lvl[1];

endmodule

// File: rtl/pwmaq_checker.sv
module pwmaq_checker #(
  parameter int CNT_W = 16,
  parameter int ACT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_up,
  input logic             zero_hit,
  input logic             period_hit,
  input logic             out_a,
  input logic             out_b,
  input logic [CNT_W-1:0] cmp_a_q,
  input logic [CNT_W-1:0] cmp_b_q,
  input logic [ACT_W-1:0] act_a,
  input logic [3:0]       force_q,
  input logic [1:0]       rld_q,
  input logic [1:0]       chan_lvl
);

  // R1: pins low while reset is held
  always @(posedge clk) begin
    if (!rst_n) p_reset_low_r1: assert (!out_a && !out_b);
  end

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(out_a) && $stable(out_b)));

  p_force_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q[1:0] == 2'b01) |-> !out_a);

  p_force_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q[3:2] == 2'b10) |-> out_b);

  p_reload_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || (rld_q == 2'b00 && !zero_hit)) |=> $stable(force_q));

  p_down_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_up && !zero_hit && !period_hit) |=> $stable(chan_lvl));

  p_cmpb_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_up && cnt == cmp_b_q && act_a[9:8] == 2'b10) |=> chan_lvl[0]);

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && zero_hit && !period_hit && act_a[1:0] == 2'b11 &&
     !(cnt_up && (cnt == cmp_a_q || cnt == cmp_b_q)))
    |=> (chan_lvl[0] != $past(chan_lvl[0])));

endmodule

bind pwm_event_qualifier pwmaq_checker #(.CNT_W(CNT_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
  .zero_hit(zero_hit), .period_hit(period_hit), .out_a(out_a), .out_b(out_b),
  .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q), .act_a(act_q[0]),
  .force_q(force_q), .rld_q(rld_q), .chan_lvl(chan_lvl)
);

// File: tb/tb_pwm_event_qualifier.sv
module tb_pwm_event_qualifier;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [15:0] cnt;
  logic        cnt_up;
  logic        zero_hit;
  logic        period_hit;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        out_a, out_b;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pwm_event_qualifier dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
    .zero_hit(zero_hit), .period_hit(period_hit), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_a(out_a), .out_b(out_b)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic step(input logic t, input logic [15:0] c, input logic up,
                      input logic z, input logic p);
    @(negedge clk);
    tick = t; cnt = c; cnt_up = up; zero_hit = z; period_hit = p;
    @(negedge clk);
    tick = 1'b0; zero_hit = 1'b0; period_hit = 1'b0;
  endtask

  task automatic t_reset;
    check(out_a, 1'b0, "R1 reset out_a");
    check(out_b, 1'b0, "R1 reset out_b");
    step(1, 16'd0, 1, 1, 1);
    check(out_a, 1'b0, "R1 zero words keep out_a low");
    check(out_b, 1'b0, "R1 zero words keep out_b low");
  endtask

  task automatic t_codes;
    wr(3'd2, 16'h0006);
    step(1, 16'd100, 1, 1, 0);
    check(out_a, 1'b1, "R2 R3 zero field high");
    check(out_b, 1'b0, "R3 out_b unaffected by word A");
    step(1, 16'd100, 1, 0, 1);
    check(out_a, 1'b0, "R2 R3 period field low");
    wr(3'd2, 16'h0003);
    step(1, 16'd100, 1, 1, 0);
    check(out_a, 1'b1, "R2 invert first");
    step(1, 16'd100, 1, 1, 0);
    check(out_a, 1'b0, "R2 invert second");
    wr(3'd2, 16'h0000);
    step(1, 16'd100, 1, 1, 0);
    check(out_a, 1'b0, "R2 keep code");
  endtask

  task automatic t_compare;
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h0020);
    step(1, 16'd5, 1, 0, 0);
    check(out_a, 1'b1, "R3 R10 compare A up high");
    wr(3'd2, 16'h0010);
    step(1, 16'd5, 0, 0, 0);
    check(out_a, 1'b1, "R4 counting down no compare");
    step(1, 16'd5, 1, 0, 0);
    check(out_a, 1'b0, "R4 counting up compare low");
    wr(3'd1, 16'd7);
    wr(3'd2, 16'h0200);
    wr(3'd3, 16'h0200);
    step(1, 16'd7, 1, 0, 0);
    check(out_a, 1'b1, "R3 compare B acts on out_a");
    check(out_b, 1'b1, "R3 R10 compare B acts on out_b");
    step(1, 16'd5, 1, 0, 0);
    check(out_b, 1'b1, "R3 word B has no compare A action");
  endtask

  task automatic t_priority;
    wr(3'd0, 16'd9);
    wr(3'd2, 16'h0016);
    step(1, 16'd50, 1, 1, 0);
    check(out_a, 1'b1, "R5 setup zero high");
    step(1, 16'd9, 1, 1, 0);
    check(out_a, 1'b0, "R5 compare A beats zero");
    step(1, 16'd50, 1, 1, 0);
    check(out_a, 1'b1, "R5 setup zero high again");
    step(1, 16'd50, 1, 1, 1);
    check(out_a, 1'b0, "R5 period beats zero");
    wr(3'd1, 16'd9);
    wr(3'd2, 16'h0216);
    step(1, 16'd9, 1, 0, 0);
    check(out_a, 1'b1, "R5 compare B beats compare A");
  endtask

  task automatic t_gate;
    wr(3'd2, 16'h0003);
    step(0, 16'd9, 1, 1, 1);
    check(out_a, 1'b1, "R6 no tick no change");
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'h0001);
    step(1, 16'd50, 1, 1, 0);
    check(out_a, 1'b0, "R2 drive low out_a");
    check(out_b, 1'b0, "R2 drive low out_b");
    wr(3'd3, 16'h0000);
  endtask

  task automatic t_force;
    wr(3'd4, 16'h0009);
    wr(3'd5, 16'h0003);
    step(1, 16'd50, 1, 0, 0);
    check(out_a, 1'b0, "R7 R8 immediate force low out_a");
    check(out_b, 1'b1, "R7 R8 immediate force high out_b");
    wr(3'd2, 16'h0002);
    step(1, 16'd50, 1, 1, 0);
    check(out_a, 1'b0, "R7 forced pin ignores event");
    wr(3'd4, 16'h000C);
    step(1, 16'd50, 1, 0, 0);
    check(out_a, 1'b1, "R9 release shows hidden level");
    check(out_b, 1'b0, "R7 code 11 releases out_b");
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h0001);
    wr(3'd5, 16'h0000);
    step(1, 16'd50, 1, 0, 1);
    check(out_a, 1'b1, "R8 zero mode ignores period");
    step(1, 16'd50, 1, 1, 0);
    check(out_a, 1'b0, "R8 zero mode loads at zero");
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0001);
    step(1, 16'd50, 1, 1, 0);
    check(out_a, 1'b0, "R8 period mode ignores zero");
    step(1, 16'd50, 1, 0, 1);
    check(out_a, 1'b1, "R8 period mode loads at period");
    wr(3'd4, 16'h0001);
    wr(3'd5, 16'h0002);
    step(1, 16'd50, 1, 0, 0);
    check(out_a, 1'b1, "R8 either mode waits for strobe");
    step(1, 16'd50, 1, 0, 1);
    check(out_a, 1'b0, "R8 either mode loads at period");
    wr(3'd4, 16'h0000);
    step(1, 16'd50, 1, 1, 0);
    check(out_a, 1'b1, "R8 either mode loads at zero");
  endtask

  task automatic run_period(input logic inv);
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 8; k++) begin
        logic ea, eb;
        step(1, 16'(k), 1, k == 0, k == 7);
        ea = ((k < 3) || (k == 7)) ^ inv;
        eb = (k < 5) || (k == 7);
        check(out_a, ea, "R11 waveform out_a");
        check(out_b, eb, "R11 waveform out_b");
      end
    end
  endtask

  task automatic t_waveform;
    wr(3'd5, 16'h0003);
    wr(3'd0, 16'd3);
    wr(3'd1, 16'd5);
    wr(3'd2, 16'h001A);
    wr(3'd3, 16'h010A);
    run_period(1'b0);
    wr(3'd2, 16'h0025);
    run_period(1'b1);
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; cnt = '0; cnt_up = 1'b1;
    zero_hit = 1'b0; period_hit = 1'b0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check(out_a, 1'b0, "R1 out_a during reset");
    rst_n = 1'b1;
    t_reset();
    t_codes();
    t_compare();
    t_priority();
    t_gate();
    t_force();
    t_waveform();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule